// File: doc/BRIEF.md
# DDR Secure Window Filter

This block judges every DDR access against a set of programmable secure windows. Each access presents an address and a security attribute. The filter compares the megabyte index of the address (the bits above the 1 MB granule) with the start and end of each window. A non-secure access is refused when it lands in an enabled window marked secure. It is also refused when it touches no window at all and the catch-all area outside the windows is marked secure. Secure accesses always pass.

Configuration arrives on a single-cycle write port that selects one 16-bit register word by index. The upper half of each 32-bit write word is a per-bit write-enable for the lower half, so a field can be updated without a read-modify-write. A global bypass bit overrides every window and lets all traffic through. Bypass is set at reset, so memory starts fully open.

The verdict comes out registered, one clock after the access strobe. It consists of a valid flag, an allow flag and a one-cycle error pulse for each refused access.

Top module: `ddrsec_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_err` are low, bypass is set and every window is disabled, so any access is allowed.
- R2: In a configuration write, data bit i (bits [15:0]) updates only when mask bit 16+i is set. Bits whose mask bit is clear keep their value.
- R3: Window k matches when its enable bit is set and start <= addr[31:20] <= end. The end is inclusive.
- R4: A window whose start is greater than its end never matches.
- R5: A window with start 0 and end 0 covers exactly addresses 0x0000_0000 to 0x000F_FFFF.
- R6: A refused access produces `dec_valid`=1, `dec_allow`=0 and `dec_err`=1 for one cycle. An allowed access produces `dec_err`=0.
- R7: An access with `acc_secure`=1 is always allowed.
- R8: A non-secure access that matches no enabled window is refused when the default-secure bit is set, and allowed when it is clear.
- R9: While bypass is set, every access is allowed.
- R10: The verdict appears on the clock edge after the one that samples `acc_valid`=1. Without `acc_valid`, `dec_valid` and `dec_err` stay low the next cycle.
- R11: An enabled window whose secure-select bit is clear admits non-secure accesses, even when the default area is secure. An address that lies in any enabled secure window is refused, even if a non-secure window also covers it.
- R12: The register words are laid out as follows.
  - Word 2k holds window k's start in [11:0], secure-select in bit 12 and enable in bit 13.
  - Word 2k+1 holds window k's end in [11:0].
  - The last word (index 15) also holds default-secure in bit 14 and bypass in bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Register word index |
| cfg_wdata | input | 32 | [31:16] write mask, [15:0] data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access byte address |
| acc_secure | input | 1 | 1 = secure access |
| dec_valid | output | 1 | Verdict valid, one cycle after access |
| dec_allow | output | 1 | Access permitted |
| dec_err | output | 1 | One-cycle pulse on a refused access |

## Verification
The bench builds the block with its defaults: eight windows, a 32-bit address and a 1 MB granule. With these values, window 7's end word also carries the global bits, so masked writes to that shared word can be checked against both uses. The 12-bit megabyte field makes the checks at the exact start and end edges of a window, the zero window and an inverted window cheap to reach. Overlapping secure and non-secure windows, and the bypass override, are exercised under the same configuration.

// File: rtl/ddrsec_pkg.sv
// Shared constants for the DDR secure window filter.
// Assumes the megabyte field fits below the control bits (at most 12 bits).
package ddrsec_pkg;
    localparam int CFG_HALF  = 16;  // data half of a configuration word
    localparam int SEL_BIT   = 12;  // window secure-select
    localparam int EN_BIT    = 13;  // window enable
    localparam int DFLT_BIT  = 14;  // default area secure (last word only)
    localparam int BYP_BIT   = 15;  // global bypass (last word only)

    typedef struct packed {
        logic valid;
        logic allow;
        logic err;
    } verdict_t;
endpackage

// File: rtl/ddrsec_cfg_regs.sv
// Configuration storage for the window filter.
// Holds per-window start/end/select/enable plus the default and bypass bits.
// Every write applies the upper-half mask to the lower-half data.
// Assumes MB_W <= SEL_BIT so fields do not overlap the control bits.
module ddrsec_cfg_regs
    import ddrsec_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int MB_W    = 12,
    parameter int IDX_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDX_W-1:0]             idx,
    input  logic [2*CFG_HALF-1:0]        wdata,
    output logic [NUM_RGN-1:0][MB_W-1:0] st_mb,
    output logic [NUM_RGN-1:0][MB_W-1:0] ed_mb,
    output logic [NUM_RGN-1:0]           en,
    output logic [NUM_RGN-1:0]           sel,
    output logic                         dflt_sec,
    output logic                         bypass
);
    localparam int LAST_IDX = 2 * NUM_RGN - 1;

    logic [CFG_HALF-1:0] wd;
    logic [CFG_HALF-1:0] wm;

    // Split the write word into its data and mask halves.
    always_comb begin
        wd = wdata[CFG_HALF-1:0];
        wm = wdata[2*CFG_HALF-1:CFG_HALF];
    end

    // Apply a mask to one field: masked bits take new data.
    function automatic logic [MB_W-1:0] merge_mb(
        input logic [MB_W-1:0] old_v,
        input logic [MB_W-1:0] new_v,
        input logic [MB_W-1:0] msk
    );
        return (old_v & ~msk) | (new_v & msk);
    endfunction

    for (genvar r = 0; r < NUM_RGN; r++) begin : g_win
        logic hit_lo;
        logic hit_hi;

        // Decode writes to this window's two words.
        always_comb begin
            hit_lo = we && (idx == IDX_W'(2 * r));
            hit_hi = we && (idx == IDX_W'(2 * r + 1));
        end

        // Start, select and enable live in the even word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_mb[r] <= '0;
                sel[r]   <= 1'b0;
                en[r]    <= 1'b0;
            end else if (hit_lo) begin
                st_mb[r] <= merge_mb(st_mb[r], wd[MB_W-1:0], wm[MB_W-1:0]);
                if (wm[SEL_BIT]) sel[r] <= wd[SEL_BIT];
                if (wm[EN_BIT])  en[r]  <= wd[EN_BIT];
            end
        end

        // End megabyte lives in the odd word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ed_mb[r] <= '0;
            end else if (hit_hi) begin
                ed_mb[r] <= merge_mb(ed_mb[r], wd[MB_W-1:0], wm[MB_W-1:0]);
            end
        end
    end

    // Global bits share the last window's end word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_sec <= 1'b0;
            bypass   <= 1'b1;
        end else if (we && (idx == IDX_W'(LAST_IDX))) begin
            if (wm[DFLT_BIT]) dflt_sec <= wd[DFLT_BIT];
            if (wm[BYP_BIT])  bypass   <= wd[BYP_BIT];
        end
    end
endmodule

// File: rtl/ddrsec_win_match.sv
// Combinational comparison of one megabyte index against all windows.
// Reports whether any enabled window matched and whether any secure one did.
// Assumes windows with start > end are simply empty.
module ddrsec_win_match #(
    parameter int NUM_RGN = 8,
    parameter int MB_W    = 12
) (
    input  logic [MB_W-1:0]              acc_mb,
    input  logic [NUM_RGN-1:0][MB_W-1:0] st_mb,
    input  logic [NUM_RGN-1:0][MB_W-1:0] ed_mb,
    input  logic [NUM_RGN-1:0]           en,
    input  logic [NUM_RGN-1:0]           sel,
    output logic                         hit_any,
    output logic                         hit_sec
);
    logic [NUM_RGN-1:0] hit;

    for (genvar r = 0; r < NUM_RGN; r++) begin : g_cmp
        // Inclusive range test gated by the window enable.
        always_comb begin
            hit[r] = en[r] && (acc_mb >= st_mb[r]) && (acc_mb <= ed_mb[r]);
        end
    end

    // Reduce per-window hits into the two summary flags.
    always_comb begin
        hit_any = |hit;
        hit_sec = |(hit & sel);
    end
endmodule

// File: rtl/ddrsec_verdict.sv
// Registers the allow/deny verdict one cycle after the access strobe.
// Assumes match flags and configuration are stable in the strobe cycle.
module ddrsec_verdict
    import ddrsec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acc_valid,
    input  logic     acc_secure,
    input  logic     hit_any,
    input  logic     hit_sec,
    input  logic     dflt_sec,
    input  logic     bypass,
    output verdict_t verdict
);
    logic deny;

    // Non-secure traffic is refused in a secure window or a secure default area.
    always_comb begin
        deny = !acc_secure && !bypass && (hit_sec || (!hit_any && dflt_sec));
    end

    // Capture the verdict for the current access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict <= '0;
        end else begin
            verdict.valid <= acc_valid;
            verdict.allow <= acc_valid && !deny;
            verdict.err   <= acc_valid && deny;
        end
    end
endmodule

// File: rtl/ddrsec_filter.sv
// Top of the DDR secure window filter.
// Ties configuration storage, window comparison and verdict register together.
// Assumes ADDR_W - MB_SHIFT <= 12 so the megabyte field fits the word layout.
module ddrsec_filter
    import ddrsec_pkg::*;
#(
    parameter int NUM_RGN  = 8,
    parameter int ADDR_W   = 32,
    parameter int MB_SHIFT = 20,
    localparam int MB_W    = ADDR_W - MB_SHIFT,
    localparam int IDX_W   = $clog2(2 * NUM_RGN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [2*CFG_HALF-1:0] cfg_wdata,
    input  logic                  acc_valid,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_secure,
    output logic                  dec_valid,
    output logic                  dec_allow,
    output logic                  dec_err
);
    logic [NUM_RGN-1:0][MB_W-1:0] st_w;
    logic [NUM_RGN-1:0][MB_W-1:0] ed_w;
    logic [NUM_RGN-1:0]           en_w;
    logic [NUM_RGN-1:0]           sel_w;
    logic                         dflt_w;
    logic                         bypass_w;
    logic                         hit_any_w;
    logic                         hit_sec_w;
    logic [MB_W-1:0]              acc_mb;
    logic                         unused_low;
    verdict_t                     verdict_w;

    // Take the megabyte index; the byte offset is not compared.
    always_comb begin
        acc_mb     = acc_addr[ADDR_W-1:MB_SHIFT];
        unused_low = ^acc_addr[MB_SHIFT-1:0];
    end

    ddrsec_cfg_regs #(
        .NUM_RGN(NUM_RGN), .MB_W(MB_W), .IDX_W(IDX_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
        .st_mb(st_w), .ed_mb(ed_w), .en(en_w), .sel(sel_w),
        .dflt_sec(dflt_w), .bypass(bypass_w)
    );

    ddrsec_win_match #(
        .NUM_RGN(NUM_RGN), .MB_W(MB_W)
    ) match_i (
        .acc_mb(acc_mb), .st_mb(st_w), .ed_mb(ed_w), .en(en_w), .sel(sel_w),
        .hit_any(hit_any_w), .hit_sec(hit_sec_w)
    );

    ddrsec_verdict verdict_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_secure(acc_secure),
        .hit_any(hit_any_w), .hit_sec(hit_sec_w), .dflt_sec(dflt_w),
        .bypass(bypass_w), .verdict(verdict_w)
    );

    // Drive the output pins from the verdict register.
    always_comb begin
        dec_valid = verdict_w.valid;
        dec_allow = verdict_w.allow;
        dec_err   = verdict_w.err;
    end
endmodule

// File: rtl/ddrsec_filter_chk.sv
// Temporal checks for the DDR secure window filter, bound to the top.
module ddrsec_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_secure,
    input logic bypass,
    input logic dec_valid,
    input logic dec_allow,
    input logic dec_err
);
    AST_DEC_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> dec_valid); // R10
    AST_QUIET_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!dec_valid && !dec_err)); // R10
    AST_SECURE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_secure) |=> (dec_allow && !dec_err)); // R7
    AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && bypass) |=> (dec_allow && !dec_err)); // R9
    AST_ERR_MEANS_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (dec_valid && !dec_allow)); // R6
endmodule

bind ddrsec_filter ddrsec_filter_chk chk_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_secure(acc_secure),
    .bypass(bypass_w), .dec_valid(dec_valid), .dec_allow(dec_allow),
    .dec_err(dec_err)
);

// File: tb/ddrsec_filter_tb_top.sv
// Directed bench for the DDR secure window filter.
module ddrsec_filter_tb_top;
    localparam int IDX_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_secure = 1'b0;
    logic        dec_valid;
    logic        dec_allow;
    logic        dec_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ddrsec_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_secure(acc_secure), .dec_valid(dec_valid), .dec_allow(dec_allow),
        .dec_err(dec_err)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {valid,allow,err} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Masked write: data in [15:0], mask in [31:16].
    task automatic wr(input int idx, input logic [15:0] data, input logic [15:0] mask);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = IDX_W'(idx);
        cfg_wdata = {mask, data};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Single access and check of the verdict one clock later.
    task automatic access(input string req, input logic [31:0] addr,
                          input logic sec, input logic allow);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr = addr;
        acc_secure = sec;
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, {dec_valid, dec_allow, dec_err}, {1'b1, allow, !allow});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 idle after reset", {dec_valid, dec_allow, dec_err}, 3'b000);
        access("R1 open after reset", 32'h4000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_mask();
        // Set default-secure but mask off bypass: bypass must stay set.
        wr(15, 16'h4000, 16'h4000);
        access("R2 bypass untouched by masked write", 32'h4000_0000, 1'b0, 1'b1);
        wr(15, 16'h0000, 16'h8000);
        access("R8 secure default refuses", 32'h4000_0000, 1'b0, 1'b0);
        access("R7 secure access in secure default", 32'h4000_0000, 1'b1, 1'b1);
        wr(15, 16'h0000, 16'h4000);
        access("R8 non-secure default allows", 32'h4000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_window();
        // R12: window 0 start word then end word, control bits written apart.
        wr(0, 16'h0002, 16'h0FFF);
        wr(1, 16'h0005, 16'h0FFF);
        wr(0, 16'h1000, 16'h1000);
        access("R3 disabled window does not match", 32'h0030_0000, 1'b0, 1'b1);
        wr(0, 16'h2000, 16'h2000);
        access("R3 start edge", 32'h0020_0000, 1'b0, 1'b0);
        access("R3 inclusive end", 32'h005F_FFFF, 1'b0, 1'b0);
        access("R3 past end", 32'h0060_0000, 1'b0, 1'b1);
        access("R3 below start", 32'h001F_FFFF, 1'b0, 1'b1);
        access("R7 secure inside secure window", 32'h0030_0000, 1'b1, 1'b1);
    endtask

    task automatic t_zero();
        wr(6, 16'h3000, 16'h3FFF);
        wr(7, 16'h0000, 16'h0FFF);
        access("R5 zero window top byte", 32'h000F_FFFF, 1'b0, 1'b0);
        access("R5 zero window excludes 1MB", 32'h0010_0000, 1'b0, 1'b1);
    endtask

    task automatic t_inverted();
        wr(14, 16'h3009, 16'h3FFF);
        wr(15, 16'h0008, 16'h0FFF);
        access("R4 inverted window at end", 32'h0080_0000, 1'b0, 1'b1);
        access("R4 inverted window at start", 32'h0090_0000, 1'b0, 1'b1);
        access("R12 end write kept globals", 32'h4000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_overlap();
        wr(10, 16'h2100, 16'h3FFF);
        wr(11, 16'h01FF, 16'h0FFF);
        wr(15, 16'h4000, 16'h4000);
        access("R11 non-secure window admits", 32'h1000_0000, 1'b0, 1'b1);
        access("R8 uncovered address refused", 32'h2000_0000, 1'b0, 1'b0);
        wr(2, 16'h3180, 16'h3FFF);
        wr(3, 16'h0180, 16'h0FFF);
        access("R11 secure overlap wins", 32'h1800_0000, 1'b0, 1'b0);
        access("R11 rest of non-secure window", 32'h1810_0000, 1'b0, 1'b1);
    endtask

    task automatic t_bypass();
        wr(15, 16'h8000, 16'h8000);
        access("R9 bypass over secure window", 32'h1800_0000, 1'b0, 1'b1);
        access("R9 bypass over secure default", 32'h2000_0000, 1'b0, 1'b1);
        wr(15, 16'h0000, 16'h8000);
    endtask

    task automatic t_latency();
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr = 32'h0020_0000;
        acc_secure = 1'b0;
        check("R10 no verdict in strobe cycle", {dec_valid, dec_allow, dec_err}, 3'b000);
        @(negedge clk);
        acc_addr = 32'h1000_0000;
        check("R10 first of back-to-back", {dec_valid, dec_allow, dec_err}, 3'b101);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R6 second of back-to-back", {dec_valid, dec_allow, dec_err}, 3'b110);
        @(negedge clk);
        check("R6 error pulse is one cycle", {dec_valid, dec_allow, dec_err}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_window();
        t_zero();
        t_inverted();
        t_overlap();
        t_bypass();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule